// File: doc/BRIEF.md
# Power Supply Supervisor Control Core

This block is the digital sequencing core of a supervisor for a desktop power supply. A set of analog comparators outside the block reduces each rail to a flag. Over-voltage flags come from the 3.3 V, 5 V and 12 V rails and under-voltage flags from the 3.3 V and 5 V rails. Two more flags report whether the power-good input from the supply is above a low threshold (0.95 V) and above a high threshold (1.2 V). The core filters these flags and times the power-good indication. It also keeps a protection latch that shuts the supply down on a fault.

A remote on/off input (`remote_off_n`, low = supply requested on) is debounced before use. While the debounced request is "off", the latch output is forced high after a short release delay, and that same condition clears any stored fault. Under-voltage faults are blanked for a start-up window after the supply is switched on. They are also ignored when the power-good input sits below its low threshold. Every delay is a tick count of the single clock, and each tick count defaults to a value derived from a clock-frequency parameter.

Top module: `psu_guard_core`

## Requirements
- R1: A qualified fault sets `latch_out` high (1 = supply shut down) and it stays high after the fault flags return to 0. A qualified fault is any deglitched over-voltage flag, or an armed under-voltage flag with the low power-good threshold exceeded.
- R2: A fault can be stored only while the debounced remote request is "on" (`remote_off_n` = 0). A stored fault is cleared only by the remote release described in R3.
- R3: Once the debounced remote request turns "off", `pwr_ok` falls on the next clock. `latch_out` is forced high REL_TICKS clocks after the debounced request changed, and it stays high until the request returns to "on".
- R4: `remote_off_n` is debounced. A level change takes effect only after it has held for DB_TICKS consecutive clocks, and a shorter pulse has no effect.
- R5: Each comparator flag is deglitched. A change takes effect only after DG_TICKS consecutive clocks, so an over-voltage pulse of DG_TICKS-1 clocks leaves `latch_out` low, and one of DG_TICKS clocks sets it one clock later.
- R6: Under-voltage flags are ignored for UV_TICKS clocks after the debounced remote request turns "on". After that window an active under-voltage flag sets the latch on the next clock.
- R7: `pwr_ok` rises exactly PG_TICKS clocks after the internal power-good condition becomes true, and falls one clock after it becomes false.
- R8: The power-good condition holds when all of the following are true: the high power-good threshold is exceeded, no over-voltage or under-voltage flag is active, the remote request is "on", and no fault is stored. In every other case `pwr_ok` is 0, and `pwr_ok` is never 1 while `latch_out` is 1.
- R9: When `pgi_above_lo` = 0 (input below 0.95 V), under-voltage flags never set the latch and only over-voltage does. When `pgi_above_lo` = 1, both kinds set it.
- R10: During reset, `pwr_ok` = 0 and `latch_out` = 0, and all delay counters and the fault store are cleared.
- R11: Any fall of the power-good condition restarts the R7 delay from zero, so a partial count is never resumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all delays count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| ov_rail3v3 | input | 1 | Over-voltage comparator flag, 3.3 V rail |
| ov_rail5v | input | 1 | Over-voltage comparator flag, 5 V rail |
| ov_rail12v | input | 1 | Over-voltage comparator flag, 12 V rail |
| uv_rail3v3 | input | 1 | Under-voltage comparator flag, 3.3 V rail |
| uv_rail5v | input | 1 | Under-voltage comparator flag, 5 V rail |
| pgi_above_lo | input | 1 | Power-good input above the low (0.95 V) threshold |
| pgi_above_hi | input | 1 | Power-good input above the high (1.2 V) threshold |
| remote_off_n | input | 1 | Remote request, 0 = supply on, 1 = supply off |
| latch_out | output | 1 | Protection output, 1 = supply shut down |
| pwr_ok | output | 1 | Power-good indication |

## Verification
The hardest situation to reach is an under-voltage fault that becomes armed at the exact end of the start-up blanking window. The flag has to be already deglitched and the power-good input held between its thresholds. The remote request also has to have just finished its own debounce and release. The bench builds this by holding the supply off while it applies the under-voltage flag and the mid-level power-good input. It then switches the request on and samples `latch_out` on the clock before and the clock after the predicted arming edge. A full sweep covers every power-good level against every fault combination. Exact-edge checks cover each of the filters and timers.

// File: rtl/psu_guard_pkg.sv
package psu_guard_pkg;

   // Index of each comparator flag inside the packed flag vector
   typedef enum int unsigned {
      FLG_OV33  = 0,
      FLG_OV5   = 1,
      FLG_OV12  = 2,
      FLG_UV33  = 3,
      FLG_UV5   = 4,
      FLG_PGLO  = 5,
      FLG_PGHI  = 6
   } flag_idx_e;

   localparam int unsigned NUM_FLAGS = 7;
   localparam int unsigned NUM_OV    = 3;
   localparam int unsigned NUM_UV    = 2;

   // Converts a duration in microseconds into clock ticks
   function automatic int unsigned us_to_ticks(input longint unsigned clk_hz,
                                               input longint unsigned usec);
      longint unsigned t;
      t = (clk_hz * usec) / 64'd1_000_000;
      if (t == 0) t = 1;
      return int'(t);
   endfunction

endpackage

// File: rtl/pgc_filter.sv
// Level filter: the output takes a new input level only after that level
// has been present for TICKS consecutive clocks.
module pgc_filter #(
   parameter int unsigned TICKS   = 4,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (TICKS < 1) begin : g_bad_ticks
      $error("pgc_filter: TICKS must be at least 1");
   end

   if (TICKS <= 1) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dout <= RST_VAL;
         else        dout <= din;
      end
   end else begin : g_count
      localparam int unsigned CW = $clog2(TICKS);
      localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            dout  <= RST_VAL;
         end else if (din == dout) begin
            cnt_q <= '0;
         end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            dout  <= din;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pgc_delay.sv
// Qualified delay: done rises TICKS clocks after en becomes 1, and clears
// (together with the count) on the clock after en drops.
module pgc_delay #(
   parameter int unsigned TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic done
);

   if (TICKS < 1) begin : g_bad_ticks
      $error("pgc_delay: TICKS must be at least 1");
   end

   localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         done  <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         done  <= 1'b0;
      end else if (!done) begin
         if (cnt_q == LAST) done  <= 1'b1;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/psu_guard_core.sv
module psu_guard_core
   import psu_guard_pkg::*;
#(
   parameter longint unsigned CLK_HZ    = 64'd50_000_000,
   parameter int unsigned     DG_TICKS  = us_to_ticks(CLK_HZ, 64'd73),
   parameter int unsigned     DB_TICKS  = us_to_ticks(CLK_HZ, 64'd38_000),
   parameter int unsigned     UV_TICKS  = us_to_ticks(CLK_HZ, 64'd75_000),
   parameter int unsigned     REL_TICKS = us_to_ticks(CLK_HZ, 64'd2_400),
   parameter int unsigned     PG_TICKS  = us_to_ticks(CLK_HZ, 64'd300_000)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ov_rail3v3,
   input  logic ov_rail5v,
   input  logic ov_rail12v,
   input  logic uv_rail3v3,
   input  logic uv_rail5v,
   input  logic pgi_above_lo,
   input  logic pgi_above_hi,
   input  logic remote_off_n,
   output logic latch_out,
   output logic pwr_ok
);

   if (DG_TICKS < 1 || DB_TICKS < 1 || UV_TICKS < 1 ||
       REL_TICKS < 1 || PG_TICKS < 1) begin : g_bad_cfg
      $error("psu_guard_core: every tick count must be at least 1");
   end

   // ---------------------------------------------------------------
   // Comparator flag deglitch
   // ---------------------------------------------------------------
   logic [NUM_FLAGS-1:0] raw_flags;
   logic [NUM_FLAGS-1:0] flt_flags;

   always_comb begin
      raw_flags           = '0;
      raw_flags[FLG_OV33] = ov_rail3v3;
      raw_flags[FLG_OV5]  = ov_rail5v;
      raw_flags[FLG_OV12] = ov_rail12v;
      raw_flags[FLG_UV33] = uv_rail3v3;
      raw_flags[FLG_UV5]  = uv_rail5v;
      raw_flags[FLG_PGLO] = pgi_above_lo;
      raw_flags[FLG_PGHI] = pgi_above_hi;
   end

   for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_deglitch
      pgc_filter #(
         .TICKS   (DG_TICKS),
         .RST_VAL (1'b0)
      ) u_flt (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (raw_flags[gi]),
         .dout  (flt_flags[gi])
      );
   end

   logic ov_any;
   logic uv_any;
   logic pgi_lo_f;
   logic pgi_hi_f;

   assign ov_any   = |flt_flags[FLG_OV12:FLG_OV33];
   assign uv_any   = |flt_flags[FLG_UV5:FLG_UV33];
   assign pgi_lo_f = flt_flags[FLG_PGLO];
   assign pgi_hi_f = flt_flags[FLG_PGHI];

   // ---------------------------------------------------------------
   // Remote request debounce (resets to "off")
   // ---------------------------------------------------------------
   logic rem_db;

   pgc_filter #(
      .TICKS   (DB_TICKS),
      .RST_VAL (1'b1)
   ) u_remote_db (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (remote_off_n),
      .dout  (rem_db)
   );

   // ---------------------------------------------------------------
   // Timers: under-voltage arming, shutdown release, power-good
   // ---------------------------------------------------------------
   logic uv_armed;
   logic off_q;
   logic pg_done;
   logic pg_cond;
   logic fault_q;

   pgc_delay #(.TICKS(UV_TICKS)) u_uv_arm (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (!rem_db),
      .done  (uv_armed)
   );

   pgc_delay #(.TICKS(REL_TICKS)) u_release (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (rem_db),
      .done  (off_q)
   );

   assign pg_cond = pgi_hi_f && !ov_any && !uv_any && !rem_db && !fault_q;

   pgc_delay #(.TICKS(PG_TICKS)) u_pg_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (pg_cond),
      .done  (pg_done)
   );

   // ---------------------------------------------------------------
   // Fault store: set has priority, clear comes from the release timer
   // ---------------------------------------------------------------
   logic uv_fault;
   logic set_fault;

   assign uv_fault  = uv_any && uv_armed && pgi_lo_f;
   assign set_fault = !rem_db && (ov_any || uv_fault);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fault_q <= 1'b0;
      else if (set_fault) fault_q <= 1'b1;
      else if (off_q)     fault_q <= 1'b0;
   end

   assign latch_out = fault_q || off_q;
   assign pwr_ok    = pg_done && !fault_q;

endmodule

// File: rtl/psu_guard_chk.sv
module psu_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic pwr_ok,
   input logic latch_out,
   input logic rem_db,
   input logic off_q,
   input logic fault_q,
   input logic pg_cond,
   input logic uv_armed,
   input logic ov_any,
   input logic pgi_lo_f
);

   AST_PGO_NOT_WITH_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_ok |-> !latch_out); // R8

   AST_PGO_AFTER_COND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_ok) |-> $past(pg_cond)); // R7

   AST_RELEASE_NEEDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(off_q) |-> $past(rem_db)); // R3

   AST_SET_ONLY_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_q) |-> !$past(rem_db)); // R2

   AST_CLEAR_BY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_q) |-> $past(off_q)); // R2

   AST_UV_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fault_q) && !$past(ov_any)) |-> ($past(uv_armed) && $past(pgi_lo_f))); // R9

endmodule

bind psu_guard_core psu_guard_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_ok    (pwr_ok),
   .latch_out (latch_out),
   .rem_db    (rem_db),
   .off_q     (off_q),
   .fault_q   (fault_q),
   .pg_cond   (pg_cond),
   .uv_armed  (uv_armed),
   .ov_any    (ov_any),
   .pgi_lo_f  (pgi_lo_f)
);

// File: tb/psu_guard_core_tb.sv
module psu_guard_core_tb;

   localparam int DG  = 3;
   localparam int DB  = 5;
   localparam int UVD = 8;
   localparam int REL = 4;
   localparam int PG  = 10;
   localparam int WAIT_OFF = DB + REL + DG + 5;
   localparam int WAIT_ON  = DB + UVD + DG + PG + 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ov33 = 0, ov5 = 0, ov12 = 0, uv33 = 0, uv5 = 0;
   logic pglo = 0, pghi = 0;
   logic rem_n = 1'b1;
   logic latch_out, pwr_ok;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   psu_guard_core #(
      .DG_TICKS  (DG),
      .DB_TICKS  (DB),
      .UV_TICKS  (UVD),
      .REL_TICKS (REL),
      .PG_TICKS  (PG)
   ) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .ov_rail3v3   (ov33),
      .ov_rail5v    (ov5),
      .ov_rail12v   (ov12),
      .uv_rail3v3   (uv33),
      .uv_rail5v    (uv5),
      .pgi_above_lo (pglo),
      .pgi_above_hi (pghi),
      .remote_off_n (rem_n),
      .latch_out    (latch_out),
      .pwr_ok       (pwr_ok)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic clear_flags();
      ov33 = 0; ov5 = 0; ov12 = 0; uv33 = 0; uv5 = 0;
   endtask

   task automatic bring_up();
      clear_flags();
      pglo = 1; pghi = 1;
      rem_n = 1;
      tick(WAIT_OFF);
      rem_n = 0;
      tick(WAIT_ON);
   endtask

   initial begin
      tick(3);
      check("R10 pwr_ok in reset", pwr_ok, 1'b0);
      check("R10 latch_out in reset", latch_out, 1'b0);
      rst_n = 1'b1;
      tick(1);

      // Sweep: power-good level x under-voltage x over-voltage (R1 R8 R9 R3)
      for (int k = 0; k < 12; k++) begin
         int lvl = k / 4;
         bit uvb = k[1];
         bit ovb = k[0];
         bit exp_l, exp_ok;
         clear_flags();
         rem_n = 1;
         pglo = (lvl >= 1);
         pghi = (lvl == 2);
         if (ovb) begin
            if (k % 3 == 0) ov33 = 1; else if (k % 3 == 1) ov5 = 1; else ov12 = 1;
         end
         if (uvb) begin
            if (k % 2 == 0) uv33 = 1; else uv5 = 1;
         end
         tick(WAIT_OFF);
         check("R3 latch forced while off", latch_out, 1'b1);
         check("R3 pwr_ok low while off", pwr_ok, 1'b0);
         rem_n = 0;
         tick(WAIT_ON);
         exp_l  = ovb || (uvb && lvl >= 1);
         exp_ok = (lvl == 2) && !uvb && !ovb;
         check("R9 R1 latch vs level/faults", latch_out, exp_l);
         check("R8 pwr_ok vs level/faults", pwr_ok, exp_ok);
      end

      bring_up();
      check("R2 latch cleared by remote cycle", latch_out, 1'b0);
      check("R8 pwr_ok good state", pwr_ok, 1'b1);

      // R5: deglitch of an over-voltage pulse
      ov12 = 1; tick(DG - 1); ov12 = 0;
      tick(5);
      check("R5 short pulse no latch", latch_out, 1'b0);
      check("R5 short pulse pwr_ok kept", pwr_ok, 1'b1);
      ov12 = 1; tick(DG);
      check("R5 latch before deglitch edge", latch_out, 1'b0);
      tick(1);
      check("R5 latch on deglitch edge", latch_out, 1'b1);
      check("R8 pwr_ok low with fault", pwr_ok, 1'b0);
      ov12 = 0; tick(20);
      check("R1 latch held after fault gone", latch_out, 1'b1);
      check("R2 fault not cleared while on", pwr_ok, 1'b0);
      bring_up();

      // R7: power-good delay edges
      pghi = 0; tick(DG);
      check("R7 pwr_ok before fall edge", pwr_ok, 1'b1);
      tick(1);
      check("R7 pwr_ok falls", pwr_ok, 1'b0);
      pghi = 1; tick(DG + PG - 1);
      check("R7 pwr_ok one before rise", pwr_ok, 1'b0);
      tick(1);
      check("R7 pwr_ok rises", pwr_ok, 1'b1);

      // R11: interrupted count restarts from zero
      pghi = 0; tick(DG + 3);
      pghi = 1; tick(DG + 4);
      pghi = 0; tick(DG + 2);
      pghi = 1; tick(DG + PG - 1);
      check("R11 no resumed count", pwr_ok, 1'b0);
      tick(1);
      check("R11 full delay after restart", pwr_ok, 1'b1);

      // R4: short remote pulse ignored
      rem_n = 1; tick(DB - 1); rem_n = 0;
      tick(DB + 5);
      check("R4 short remote pulse pwr_ok", pwr_ok, 1'b1);
      check("R4 short remote pulse latch", latch_out, 1'b0);

      // R3: remote off timing
      rem_n = 1; tick(DB);
      check("R4 pwr_ok before debounce edge", pwr_ok, 1'b1);
      tick(1);
      check("R3 pwr_ok falls after debounce", pwr_ok, 1'b0);
      tick(REL - 2);
      check("R3 latch one before release", latch_out, 1'b0);
      tick(1);
      check("R3 latch forced after release", latch_out, 1'b1);

      // R6: under-voltage blanking window, mid power-good level
      uv5 = 1; pglo = 1; pghi = 0;
      tick(DG + 5);
      rem_n = 0;
      tick(DB + 1);
      check("R6 latch released, uv blanked", latch_out, 1'b0);
      tick(UVD - 1);
      check("R6 latch one before arming", latch_out, 1'b0);
      tick(1);
      check("R6 latch on arming edge", latch_out, 1'b1);

      bring_up();
      check("R2 final clear", latch_out, 1'b0);
      check("R8 final power good", pwr_ok, 1'b1);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule